// File: doc/BRIEF.md
# Interrupt Aggregator with Intrusion-Clear Pulse

This block gathers interrupt events for a hardware health monitor and presents them to a host. Limit-check results from the analog, temperature and fan channels arrive as single-cycle pulses on `limit_evt`. One more source comes from an external chassis-intrusion detector on `intr_in`, which is asynchronous and active high. Each event sets a sticky bit in one of two status registers. A single interrupt line, `irq`, is raised whenever any status bit is set whose bit in the two mask registers is clear.

The host reaches the registers through a simple synchronous port. A strobe on `wr_en` writes `wdata` into the register selected by `addr`. A strobe on `rd_en` returns the selected register on `rdata` one cycle later, and reading a status register clears it. The external intrusion detector latches its own event. To reset that latch, the host sets the clear bit of the clear register. The block then asserts `intr_pull`, which is the enable of an open-drain pull-down on the intrusion line, for a fixed time of at least 20 ms. The clear bit then drops back to zero without a second host write. While the line is held low, and for a short guard time after it is released, the intrusion input is ignored.

Top module: `intr_aggregator`

## Requirements
- R1: After reset `irq`, `intr_pull` and `rdata` are 0, both status registers are 0, and both mask registers read 0xFF.
- R2: A pulse on `limit_evt[i]` sets status bit i, which maps to status register 0x41 bit i for i<8 and to status register 0x42 bit i-8 otherwise. The bit is set on the clock edge that samples the pulse, whatever the mask holds.
- R3: A status bit stays set until its own register is read. A read strobe returns the register value on `rdata` after the next edge and clears only that register. An event sampled on the same edge as the read stays set and is absent from the returned value.
- R4: A high level on `intr_in` sets status register 0x42 bit 7. The level passes through SYNC_STAGES synchronizer flops, so with the default of 2, a level applied before edge k shows at edge k+2.
- R5: `irq` is 1 exactly when some status bit is 1 and its mask bit is 0. Mask registers 0x43 and 0x44 line up bit for bit with status registers 0x41 and 0x42, and a write to a mask register replaces all of its bits.
- R6: A write with bit 7 set to clear register 0x45 raises `intr_pull` from the next edge. It stays high for exactly CLK_HZ/1000*PULSE_MS cycles, which is 20 ms by default. A write with bit 7 clear does nothing, and a write made while the pulse is running does not restart it.
- R7: The intrusion input is ignored while `intr_pull` is high and for SYNC_STAGES cycles after it falls.
- R8: Reading register 0x45 returns bit 7 = 1 while the pulse is running and 0 after it ends. The other bits read 0.
- R9: Writes to the status registers are ignored. A read of any address that is not mapped returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| limit_evt | input | 15 | Single-cycle pulses from the limit comparators, one per channel |
| intr_in | input | 1 | External intrusion level, active high, asynchronous |
| intr_pull | output | 1 | Enable for the pull-down that holds the intrusion line low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered, valid the cycle after `rd_en` |
| irq | output | 1 | Interrupt output, the OR of the unmasked status bits |

## Verification
The bench runs a long seeded random stream of sparse limit events mixed with status reads and random mask writes. This stream separates sticky set-and-clear behaviour from the mask gating, because every cycle the output is compared with a model of both. Directed cases then target the points that random traffic reaches only rarely:
- an event arriving on the same edge as the read that clears its register, which separates set priority from clear priority;
- a one-cycle intrusion level, which tells the synchronizer latency apart from a direct path;
- an intrusion level held through the whole pulse and dropped right at its end, which separates a correct guard window from one that ends too early.

// File: rtl/intr_agg_pkg.sv
`timescale 1ns/1ps
package intr_agg_pkg;
   // the aggregator always exposes a pair of status/mask registers
   localparam int unsigned NUM_BANKS = 2;
   // default register map
   localparam int unsigned DEF_ADDR_STAT0 = 'h41;
   localparam int unsigned DEF_ADDR_STAT1 = 'h42;
   localparam int unsigned DEF_ADDR_MASK0 = 'h43;
   localparam int unsigned DEF_ADDR_MASK1 = 'h44;
   localparam int unsigned DEF_ADDR_CLR   = 'h45;
endpackage

// File: rtl/intr_sync.sv
`timescale 1ns/1ps
// Shift chain exposing every tap; used both as input synchronizer and as a
// short history of a signal.
module intr_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              d,
   output logic [STAGES-1:0] taps
);
   if (STAGES < 1) begin : g_bad_stages
      $error("intr_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] sh_q;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= d;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= {sh_q[STAGES-2:0], d};
      end
   end

   assign taps = sh_q;
endmodule

// File: rtl/intr_stat_reg.sv
`timescale 1ns/1ps
// One sticky status register: set wins over the read-clear of the same edge.
module intr_stat_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic         clr,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("intr_stat_reg: W must be at least 1");
   end

   logic [W-1:0] q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= (clr ? '0 : q_r) | set;
   end

   assign q = q_r;
endmodule

// File: rtl/intr_pulse_timer.sv
`timescale 1ns/1ps
// Fixed-length one-shot; a start request while running is dropped.
module intr_pulse_timer #(
   parameter int unsigned CYCLES = 20,
   parameter int unsigned CNT_W  = $clog2(CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active
);
   if (CYCLES < 1) begin : g_bad_cycles
      $error("intr_pulse_timer: CYCLES must be at least 1");
   end

   localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= 1'b0;
      end else if (act_q) begin
         if (cnt_q == '0) act_q <= 1'b0;
         else             cnt_q <= cnt_q - CNT_W'(1);
      end else if (start) begin
         act_q <= 1'b1;
         cnt_q <= LOAD;
      end
   end

   assign active = act_q;
endmodule

// File: rtl/intr_aggregator.sv
`timescale 1ns/1ps
module intr_aggregator
   import intr_agg_pkg::*;
#(
   parameter int unsigned REG_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CLK_HZ      = 125_000_000,
   parameter int unsigned PULSE_MS    = 20,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned CLR_BIT     = 7,
   parameter logic [ADDR_W-1:0] ADDR_STAT0 = ADDR_W'(DEF_ADDR_STAT0),
   parameter logic [ADDR_W-1:0] ADDR_STAT1 = ADDR_W'(DEF_ADDR_STAT1),
   parameter logic [ADDR_W-1:0] ADDR_MASK0 = ADDR_W'(DEF_ADDR_MASK0),
   parameter logic [ADDR_W-1:0] ADDR_MASK1 = ADDR_W'(DEF_ADDR_MASK1),
   parameter logic [ADDR_W-1:0] ADDR_CLR   = ADDR_W'(DEF_ADDR_CLR)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_BANKS*REG_W-2:0]     limit_evt,
   input  logic                           intr_in,
   output logic                           intr_pull,
   input  logic                           wr_en,
   input  logic                           rd_en,
   input  logic [ADDR_W-1:0]              addr,
   input  logic [REG_W-1:0]               wdata,
   output logic [REG_W-1:0]               rdata,
   output logic                           irq
);
   localparam int unsigned NUM_SRC      = NUM_BANKS * REG_W;
   localparam int unsigned PULSE_CYCLES = (CLK_HZ / 1000) * PULSE_MS;
   localparam int unsigned PULSE_CNT_W  = $clog2(PULSE_CYCLES + 1);
   localparam logic [NUM_BANKS-1:0][ADDR_W-1:0] STAT_ADDRS = {ADDR_STAT1, ADDR_STAT0};
   localparam logic [NUM_BANKS-1:0][ADDR_W-1:0] MASK_ADDRS = {ADDR_MASK1, ADDR_MASK0};

   // elaboration-time parameter checks
   if (CLR_BIT >= REG_W) begin : g_bad_clr_bit
      $error("intr_aggregator: CLR_BIT must lie inside REG_W");
   end
   if (PULSE_CYCLES < 1) begin : g_bad_pulse
      $error("intr_aggregator: CLK_HZ/1000*PULSE_MS must be at least 1");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("intr_aggregator: SYNC_STAGES must be at least 1");
   end
   if (ADDR_W < 1 || REG_W < 1) begin : g_bad_width
      $error("intr_aggregator: widths must be non-zero");
   end

   // intrusion input path
   logic [SYNC_STAGES-1:0] intr_taps;
   logic [SYNC_STAGES-1:0] pull_taps;
   logic                   intr_ignore;
   logic                   intr_evt;

   intr_sync #(.STAGES(SYNC_STAGES)) u_intr_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (intr_in),
      .taps (intr_taps)
   );

   // history of the pull so that values caught in the synchronizer while
   // the line was held low are discarded as well
   intr_sync #(.STAGES(SYNC_STAGES)) u_pull_hist (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (intr_pull),
      .taps (pull_taps)
   );

   assign intr_ignore = intr_pull | (|pull_taps);
   assign intr_evt    = intr_taps[SYNC_STAGES-1] & ~intr_ignore;

   // clear-pulse one-shot
   logic pulse_start;

   assign pulse_start = wr_en && (addr == ADDR_CLR) && wdata[CLR_BIT];

   intr_pulse_timer #(
      .CYCLES(PULSE_CYCLES),
      .CNT_W (PULSE_CNT_W)
   ) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .start (pulse_start),
      .active(intr_pull)
   );

   // status and mask banks
   logic [NUM_SRC-1:0]                src_set;
   logic [NUM_SRC-1:0]                stat_all;
   logic [NUM_SRC-1:0]                mask_all;
   logic [NUM_BANKS-1:0][REG_W-1:0]   stat_q;
   logic [NUM_BANKS-1:0][REG_W-1:0]   mask_q;
   logic [NUM_BANKS-1:0]              stat_rd;

   assign src_set = {intr_evt, limit_evt};

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign stat_rd[b] = rd_en && (addr == STAT_ADDRS[b]);

      intr_stat_reg #(.W(REG_W)) u_stat (
         .clk  (clk),
         .rst_n(rst_n),
         .set  (src_set[b*REG_W +: REG_W]),
         .clr  (stat_rd[b]),
         .q    (stat_q[b])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mask_q[b] <= '1;
         else if (wr_en && (addr == MASK_ADDRS[b]))
            mask_q[b] <= wdata;
      end

      assign stat_all[b*REG_W +: REG_W] = stat_q[b];
      assign mask_all[b*REG_W +: REG_W] = mask_q[b];
   end

   assign irq = |(stat_all & ~mask_all);

   // read path
   logic [REG_W-1:0] rd_val;
   logic [REG_W-1:0] rdata_q;

   always_comb begin
      rd_val = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (addr == STAT_ADDRS[b]) rd_val = stat_q[b];
         if (addr == MASK_ADDRS[b]) rd_val = mask_q[b];
      end
      if (addr == ADDR_CLR) rd_val[CLR_BIT] = intr_pull;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata_q <= '0;
      else if (rd_en) rdata_q <= rd_val;
   end

   assign rdata = rdata_q;
endmodule

// File: rtl/intr_aggregator_chk.sv
`timescale 1ns/1ps
module intr_aggregator_chk #(
   parameter int unsigned REG_W        = 8,
   parameter int unsigned NUM_SRC      = 16,
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned CLR_BIT      = 7,
   parameter int unsigned PULSE_CYCLES = 20,
   parameter logic [ADDR_W-1:0] ADDR_STAT0 = '0,
   parameter logic [ADDR_W-1:0] ADDR_STAT1 = '0,
   parameter logic [ADDR_W-1:0] ADDR_CLR   = '0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               rd_en,
   input logic [ADDR_W-1:0]  addr,
   input logic [REG_W-1:0]   rdata,
   input logic               irq,
   input logic               intr_pull,
   input logic [NUM_SRC-1:0] src_set,
   input logic [NUM_SRC-1:0] stat_all,
   input logic [NUM_SRC-1:0] mask_all
);
   int unsigned hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hi_cnt <= 0;
      else if (intr_pull) hi_cnt <= hi_cnt + 1;
      else                hi_cnt <= 0;
   end

   // R2: every sampled event is present in the status the next cycle
   p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|src_set) |=> ((stat_all & $past(src_set)) == $past(src_set)));

   // R3: without a read of its register, no status bit of bank 0 drops
   p_sticky0_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && addr == ADDR_STAT0) |=>
      ((stat_all[REG_W-1:0] & $past(stat_all[REG_W-1:0])) == $past(stat_all[REG_W-1:0])));

   // R3: same for bank 1
   p_sticky1_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && addr == ADDR_STAT1) |=>
      ((stat_all[NUM_SRC-1:REG_W] & $past(stat_all[NUM_SRC-1:REG_W])) == $past(stat_all[NUM_SRC-1:REG_W])));

   // R5: fully masked means no interrupt
   p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_all) |-> !irq);

   // R6: the pull lasts exactly the configured number of cycles
   p_pulse_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(intr_pull) |-> (hi_cnt == PULSE_CYCLES));

   // R7: no intrusion status rising while the line is held low
   p_intr_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      intr_pull |=> !$rose(stat_all[NUM_SRC-1]));

   // R8: clear register read returns the pulse state
   p_clr_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_CLR) |=> (rdata[CLR_BIT] == $past(intr_pull)));
endmodule

bind intr_aggregator intr_aggregator_chk #(
   .REG_W       (REG_W),
   .NUM_SRC     (NUM_SRC),
   .ADDR_W      (ADDR_W),
   .CLR_BIT     (CLR_BIT),
   .PULSE_CYCLES(PULSE_CYCLES),
   .ADDR_STAT0  (ADDR_STAT0),
   .ADDR_STAT1  (ADDR_STAT1),
   .ADDR_CLR    (ADDR_CLR)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_en    (rd_en),
   .addr     (addr),
   .rdata    (rdata),
   .irq      (irq),
   .intr_pull(intr_pull),
   .src_set  (src_set),
   .stat_all (stat_all),
   .mask_all (mask_all)
);

// File: tb/intr_aggregator_tb.sv
`timescale 1ns/1ps
module intr_aggregator_tb;
   localparam int unsigned CLK_HZ = 1_000_000;
   localparam int unsigned PULSE  = (CLK_HZ / 1000) * 20;
   localparam logic [7:0] A_ST0 = 8'h41, A_ST1 = 8'h42, A_MK0 = 8'h43,
                          A_MK1 = 8'h44, A_CLR = 8'h45;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [14:0] limit_evt = '0;
   logic        intr_in = 1'b0;
   logic        intr_pull;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]  addr = '0, wdata = '0, rdata;
   logic        irq;

   int n_vec = 0;
   int n_err = 0;
   logic [15:0] exp_stat = '0;
   logic [15:0] exp_mask = '1;

   always #4 clk = ~clk;

   intr_aggregator #(.CLK_HZ(CLK_HZ)) u_dut (
      .clk(clk), .rst_n(rst_n), .limit_evt(limit_evt), .intr_in(intr_in),
      .intr_pull(intr_pull), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   function automatic logic f_irq(logic [15:0] s, logic [15:0] m);
      return |(s & ~m);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one model-checked cycle of limit events and register traffic
   task automatic cyc(logic [14:0] evt, logic wr, logic rd, logic [7:0] a, logic [7:0] d);
      logic [7:0] exp_rd;
      limit_evt = evt; wr_en = wr; rd_en = rd; addr = a; wdata = d;
      exp_rd = 8'h00;
      if (rd) begin
         case (a)
            A_ST0: begin exp_rd = exp_stat[7:0];  exp_stat[7:0]  = '0; end
            A_ST1: begin exp_rd = exp_stat[15:8]; exp_stat[15:8] = '0; end
            A_MK0: exp_rd = exp_mask[7:0];
            A_MK1: exp_rd = exp_mask[15:8];
            default: exp_rd = 8'h00;
         endcase
      end
      if (wr) begin
         if (a == A_MK0) exp_mask[7:0]  = d;
         if (a == A_MK1) exp_mask[15:8] = d;
      end
      exp_stat = exp_stat | {1'b0, evt};
      @(negedge clk);
      chk("R5 irq", irq, f_irq(exp_stat, exp_mask));
      if (rd) chk("R3/R9 rdata", rdata, exp_rd);
      limit_evt = '0; wr_en = 0; rd_en = 0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         limit_evt = '0; wr_en = 0; rd_en = 0;
         @(negedge clk);
      end
   endtask

   initial begin
      #(8 * 150000);
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end

   initial begin
      int cnt;
      logic [14:0] e;
      logic [3:0]  op;
      void'($urandom(32'h5eed));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 irq", irq, 1'b0);
      chk("R1 intr_pull", intr_pull, 1'b0);
      chk("R1 rdata", rdata, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      cyc('0, 0, 1, A_MK0, 0);
      cyc('0, 0, 1, A_MK1, 0);
      cyc('0, 0, 1, A_ST1, 0);

      // R2 visible while masked, then R5 unmask
      cyc(15'h0001, 0, 0, 0, 0);
      cyc(15'h4000, 0, 0, 0, 0);
      cyc('0, 0, 1, A_ST1, 0);            // R2 bit 14 -> 0x42 bit 6
      cyc('0, 1, 0, A_MK0, 8'hFE);        // R5 unmask bit0 -> irq
      // R3 event coinciding with the read of its register
      cyc(15'h0003, 0, 1, A_ST0, 0);
      cyc('0, 0, 1, A_ST0, 0);
      // R9 status write ignored, unmapped read
      cyc(15'h0010, 0, 0, 0, 0);
      cyc('0, 1, 0, A_ST0, 8'hFF);
      cyc('0, 0, 1, A_ST0, 0);
      cyc('0, 0, 1, 8'h50, 0);

      // constrained random traffic
      for (int i = 0; i < 3000; i++) begin
         e  = ($urandom % 6 == 0) ? 15'($urandom) & 15'($urandom) : '0;
         op = 4'($urandom % 10);
         case (op)
            4'd0: cyc(e, 0, 1, A_ST0, 0);
            4'd1: cyc(e, 0, 1, A_ST1, 0);
            4'd2: cyc(e, 1, 0, A_MK0, 8'($urandom));
            4'd3: cyc(e, 1, 0, A_MK1, 8'($urandom));
            4'd4: cyc(e, 0, 1, ($urandom % 2) ? A_MK0 : A_MK1, 0);
            default: cyc(e, 0, 0, 0, 0);
         endcase
      end

      // prepare: only intrusion bit unmasked, status cleared
      cyc('0, 1, 0, A_MK0, 8'hFF);
      cyc('0, 1, 0, A_MK1, 8'h7F);
      cyc('0, 0, 1, A_ST0, 0);
      cyc('0, 0, 1, A_ST1, 0);
      chk("R5 irq quiet", irq, 1'b0);

      // R4 synchronizer latency with a one-cycle level
      intr_in = 1'b1;
      @(negedge clk);
      chk("R4 not after 1 edge", irq, 1'b0);
      intr_in = 1'b0;
      @(negedge clk);
      chk("R4 not after 2 edges", irq, 1'b0);
      @(negedge clk);
      chk("R4 set after 3rd edge", irq, 1'b1);
      rd_en = 1; addr = A_ST1;
      @(negedge clk);
      rd_en = 0;
      chk("R4 status bit", rdata, 8'h80);
      chk("R3 cleared by read", irq, 1'b0);
      idle(4);

      // R6 write without bit 7 does nothing
      wr_en = 1; addr = A_CLR; wdata = 8'h7F;
      @(negedge clk);
      wr_en = 0;
      chk("R6 no start", intr_pull, 1'b0);
      idle(2);
      chk("R6 still idle", intr_pull, 1'b0);

      // R6/R7/R8 pulse with the intrusion input held high throughout
      wr_en = 1; addr = A_CLR; wdata = 8'h80; intr_in = 1'b1;
      @(negedge clk);
      wr_en = 0;
      chk("R6 started", intr_pull, 1'b1);
      cnt = 0;
      while (intr_pull && cnt < PULSE + 100) begin
         cnt++;
         if (cnt == 101) chk("R8 active readback", rdata, 8'h80);
         rd_en = (cnt == 100);
         wr_en = (cnt == 200);
         addr  = A_CLR; wdata = 8'h80;
         @(negedge clk);
      end
      rd_en = 0; wr_en = 0; intr_in = 1'b0;
      chk("R6 pulse length", cnt, PULSE);
      idle(6);
      chk("R7 no false intrusion irq", irq, 1'b0);
      rd_en = 1; addr = A_ST1;
      @(negedge clk);
      rd_en = 0;
      chk("R7 no false intrusion status", rdata, 8'h00);
      rd_en = 1; addr = A_CLR;
      @(negedge clk);
      rd_en = 0;
      chk("R8 self-cleared", rdata, 8'h00);
      // intrusion is sensed again after the guard window
      intr_in = 1'b1;
      idle(4);
      intr_in = 1'b0;
      chk("R4 sensed after pulse", irq, 1'b1);

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end
endmodule